// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block generates several edge-aligned pulse-width-modulated outputs from a single up-counter. One prescaler and one modulo (period) value are common to every channel; each channel adds its own compare value and its own output mode. The output mode can be normal (high-true), inverted, or off. A channel's duty cycle is set only by its compare value, so channels with different duty cycles and polarities run side by side on the same period.

Software drives the block through a small register bus that addresses bytes but transfers whole words. Each access finishes in the cycle it is presented: a write takes effect at the clock edge where `bus_sel` and `bus_wr` are high, and `bus_rdata` follows `bus_addr` combinationally. The bus has no back-pressure and no wait states. While the counter is stopped, writes to the period and compare registers take effect at once. While the counter runs, those writes are held in a shadow copy and move into the active copy when the counter wraps, so a period is never cut short or stretched part-way through. Changes to a channel's mode bits reach its output pin at once.

Top module: `pwm_shared_timer`

## Requirements
- R1: Address 0x04 reads the number of channels in bits [7:0] and ignores writes. Address 0x08 reads as zero.
- R2: The control register at 0x10 holds the prescale exponent in bits [2:0] and the run mode in bits [4:3]. It resets to zero. Bit 5 (centre-aligned counting) always reads 0, and a write to it has no effect.
- R3: The counter reads at 0x14 and resets to 0. With run mode 00 it holds its value. With any other run mode it advances once every 2^prescale clocks, counts from 0 up to the active period inclusive, and then returns to 0. A write to 0x14 clears both the counter and the prescale phase.
- R4: The period register at 0x18 is 16 bits wide and resets to 0xFFFF. Channel n's compare register is at 0x24+8n and resets to 0. While the run mode is 00, a write to either register changes the value read back, and the value in use, from the next cycle on.
- R5: While the run mode is non-zero, a write to a period or compare register does not change the value read back or the value in use. The written value becomes active at the edge where the counter wraps to 0.
- R6: Channel n's control register at 0x24+8n-4 holds: bit 7, the wrap flag; bit 5, edge-aligned enable; bit 4, a spare mode bit; bits [3:2], output select. Output select 10 means normal and 01 means inverted. An output is driven only when bit 5 is 1 and the select is 10 or 01. In every other case, including select 00 and select 11, the output is low.
- R7: In normal mode the output is high while the counter is below the compare value and low otherwise. A compare value of 0 therefore gives a constant low. A compare value above the period gives a constant high. Inverted mode gives the complement.
- R8: A write to a channel's control register changes its output in the cycle right after the write edge, without waiting for a period boundary.
- R9: At each wrap, every enabled channel sets its flag. Writing 1 to bit 7 clears the flag, and writing 0 leaves it unchanged. If a wrap and a clear arrive together, the flag is set. A disabled channel's flag does not change at a wrap.
- R10: Compare values and output modes are independent per channel, while all channels share the counter, the period and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | N_CH | One PWM output per channel |

## Verification
The embedded properties check, on every cycle, the relations that hold locally:
- the counter returns to 0 after a wrap and holds still while stopped;
- a shadowed register updates immediately while stopped and holds while running until a load;
- enabled channels set their flag on a wrap, and the flag stays set until a clearing write;
- a normal channel with compare 0 stays low.

Only the directed scenarios can show the things that span many cycles:
- the duty pattern over whole periods;
- the actual division rate of the prescaler;
- that a buffered value arrives exactly at the wrap and not before;
- that a mode change on one channel leaves the others alone.

The bench compares every output and readback against a cycle model built from the requirements.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  // register map (byte addresses; software-visible, so fixed)
  localparam logic [7:0] OFS_INFO    = 8'h04;
  localparam logic [7:0] OFS_GLOBAL  = 8'h08;
  localparam logic [7:0] OFS_CTRL    = 8'h10;
  localparam logic [7:0] OFS_COUNT   = 8'h14;
  localparam logic [7:0] OFS_PERIOD  = 8'h18;
  localparam int         CH_BASE     = 32;   // channel 0 control
  localparam int         CH_STRIDE   = 8;
  localparam int         CH_CMP_OFS  = 4;    // compare sits after control

  // channel output select
  typedef enum logic [1:0] {
    SEL_OFF   = 2'b00,
    SEL_INV   = 2'b01,
    SEL_NORM  = 2'b10,
    SEL_OFF_B = 2'b11
  } out_sel_e;

  typedef struct packed {
    logic     flag;
    logic     edge_en;
    logic     spare;
    out_sel_e sel;
  } chan_cfg_t;

  function automatic logic [7:0] ch_ctl_addr(input int idx);
    return 8'(CH_BASE + CH_STRIDE * idx);
  endfunction

  function automatic logic [7:0] ch_cmp_addr(input int idx);
    return 8'(CH_BASE + CH_STRIDE * idx + CH_CMP_OFS);
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [PS_W-1:0]  ps,
  input  logic             clr,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             run;
  logic             tick;

  assign run  = (mode != 2'b00);
  assign mask = ~({PRE_W{1'b1}} << ps);
  assign tick = run && ((pre_q & mask) == mask);
  assign wrap = tick && (cnt >= top) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else if (clr) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= run ? pre_q + 1'b1 : '0;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt)); // R3

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         running,
  input  logic         load,
  output logic [W-1:0] act
);

  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= INIT;
      act      <= INIT;
    end else begin
      if (wr) shadow_q <= wdata;
      if (wr && (!running || load)) act <= wdata;
      else if (load)                act <= shadow_q;
    end
  end

  AST_IDLE_WRITE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !running) |=> (act == $past(wdata))); // R4
  AST_RUN_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && running && !load) |=> $stable(act)); // R5

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic [7:0]       cfg_rd,
  output logic             pwm
);

  chan_cfg_t cfg;
  logic      en;
  logic      below;

  assign en    = cfg.edge_en && (cfg.sel == SEL_NORM || cfg.sel == SEL_INV);
  assign below = (cnt < cmp);
  assign pwm   = en && ((cfg.sel == SEL_NORM) ? below : !below);
  assign cfg_rd = {cfg.flag, 1'b0, cfg.edge_en, cfg.spare, cfg.sel, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (cfg_wr) begin
        cfg.edge_en <= cfg_wdata[5];
        cfg.spare   <= cfg_wdata[4];
        cfg.sel     <= out_sel_e'(cfg_wdata[3:2]);
      end
      if (wrap && en)                   cfg.flag <= 1'b1;
      else if (cfg_wr && cfg_wdata[7])  cfg.flag <= 1'b0;
    end
  end

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && en) |=> cfg_rd[7]); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd[7] && !(cfg_wr && cfg_wdata[7])) |=> cfg_rd[7]); // R9
  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0 && cfg.sel == SEL_NORM) |-> !pwm); // R7

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwm_tmr_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16,
  parameter int PS_W  = 3   // field sits in control bits [PS_W-1:0], PS_W <= 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [N_CH-1:0] pwm_out
);

  localparam logic [CNT_W-1:0] PERIOD_INIT = '1;

  logic             wr_hit;
  logic [1:0]       mode_q;
  logic [PS_W-1:0]  ps_q;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] cmp_act [N_CH];
  logic [7:0]       cfg_rd  [N_CH];

  assign wr_hit  = bus_sel && bus_wr;
  assign running = (mode_q != 2'b00);

  // control register: prescale and run mode; centre-aligned bit not stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ps_q   <= '0;
    end else if (wr_hit && bus_addr == OFS_CTRL) begin
      mode_q <= bus_wdata[4:3];
      ps_q   <= bus_wdata[PS_W-1:0];
    end
  end

  pwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode_q),
    .ps   (ps_q),
    .clr  (wr_hit && bus_addr == OFS_COUNT),
    .top  (per_act),
    .cnt  (cnt),
    .wrap (wrap)
  );

  pwm_shadow #(.W(CNT_W), .INIT(PERIOD_INIT)) u_period (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_hit && bus_addr == OFS_PERIOD),
    .wdata  (bus_wdata[CNT_W-1:0]),
    .running(running),
    .load   (wrap),
    .act    (per_act)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [7:0] CTL_A = ch_ctl_addr(i);
    localparam logic [7:0] CMP_A = ch_cmp_addr(i);

    pwm_shadow #(.W(CNT_W), .INIT('0)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_hit && bus_addr == CMP_A),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .running(running),
      .load   (wrap),
      .act    (cmp_act[i])
    );

    pwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (wr_hit && bus_addr == CTL_A),
      .cfg_wdata(bus_wdata[7:0]),
      .wrap     (wrap),
      .cnt      (cnt),
      .cmp      (cmp_act[i]),
      .cfg_rd   (cfg_rd[i]),
      .pwm      (pwm_out[i])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_INFO:   bus_rdata[7:0] = 8'(N_CH);
      OFS_CTRL: begin
        bus_rdata[4:3]      = mode_q;
        bus_rdata[PS_W-1:0] = ps_q;
      end
      OFS_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
      OFS_PERIOD: bus_rdata[CNT_W-1:0] = per_act;
      default: ;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == ch_ctl_addr(i)) bus_rdata[7:0]       = cfg_rd[i];
      if (bus_addr == ch_cmp_addr(i)) bus_rdata[CNT_W-1:0] = cmp_act[i];
    end
  end

  AST_INFO_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_INFO) |-> (bus_rdata == 32'(N_CH))); // R1

endmodule

// File: tb/pwm_shared_timer_test.sv
module pwm_shared_timer_test;

  localparam int NCH = 4;
  localparam logic [7:0] A_INFO = 8'h04, A_GLB = 8'h08, A_SC = 8'h10,
                         A_CNT = 8'h14, A_PER = 8'h18;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  pwm_out;

  always #10 clk = ~clk;

  pwm_shared_timer #(.N_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  int checks = 0;
  int errors = 0;

  // cycle model built from the requirements
  int       m_mode, m_ps, m_pre, m_cnt, m_per_act, m_per_buf;
  int       m_cmp_act [NCH];
  int       m_cmp_buf [NCH];
  bit       m_edge [NCH];
  bit       m_spare [NCH];
  int       m_sel [NCH];
  bit       m_flag [NCH];

  function automatic logic [7:0] ctl_a(input int i); return 8'(32 + 8*i); endfunction
  function automatic logic [7:0] cmp_a(input int i); return 8'(36 + 8*i); endfunction

  function automatic bit m_en(input int i);
    return m_edge[i] && (m_sel[i] == 2 || m_sel[i] == 1);
  endfunction

  function automatic logic [NCH-1:0] exp_out();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) begin
      bit lvl = (m_cnt < m_cmp_act[i]);
      v[i] = m_en(i) && ((m_sel[i] == 2) ? lvl : !lvl);
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_ctl(input int i);
    return {24'h0, m_flag[i], 1'b0, m_edge[i], m_spare[i], 2'(m_sel[i]), 2'b00};
  endfunction

  task automatic model_reset();
    m_mode = 0; m_ps = 0; m_pre = 0; m_cnt = 0;
    m_per_act = 16'hFFFF; m_per_buf = 16'hFFFF;
    for (int i = 0; i < NCH; i++) begin
      m_cmp_act[i] = 0; m_cmp_buf[i] = 0; m_edge[i] = 0;
      m_spare[i] = 0; m_sel[i] = 0; m_flag[i] = 0;
    end
  endtask

  task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d);
    int  mask = (1 << m_ps) - 1;
    bit  run  = (m_mode != 0);
    bit  clr  = we && (a == A_CNT);
    bit  tick = run && ((m_pre & mask) == mask);
    bit  wrap = tick && (m_cnt >= m_per_act) && !clr;
    bit  en_old [NCH];
    for (int i = 0; i < NCH; i++) en_old[i] = m_en(i);
    if (clr) begin
      m_cnt = 0; m_pre = 0;
    end else begin
      m_pre = run ? (m_pre + 1) % 128 : 0;
      if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
    end
    if (we && a == A_PER) begin
      if (!run || wrap) m_per_act = int'(d[15:0]);
      m_per_buf = int'(d[15:0]);
    end else if (wrap) m_per_act = m_per_buf;
    for (int i = 0; i < NCH; i++) begin
      if (we && a == cmp_a(i)) begin
        if (!run || wrap) m_cmp_act[i] = int'(d[15:0]);
        m_cmp_buf[i] = int'(d[15:0]);
      end else if (wrap) m_cmp_act[i] = m_cmp_buf[i];
      if (wrap && en_old[i]) m_flag[i] = 1'b1;
      else if (we && a == ctl_a(i) && d[7]) m_flag[i] = 1'b0;
      if (we && a == ctl_a(i)) begin
        m_edge[i] = d[5]; m_spare[i] = d[4]; m_sel[i] = int'(d[3:2]);
      end
    end
    if (we && a == A_SC) begin
      m_mode = int'(d[4:3]); m_ps = int'(d[2:0]);
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(1'b1, a, d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      model_edge(1'b0, 8'h00, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    chk(tag, "pwm_out", 32'(pwm_out), 32'(exp_out()));
    rd(A_CNT, d);    chk(tag, "counter", d, 32'(m_cnt));
    rd(A_PER, d);    chk(tag, "period", d, 32'(m_per_act));
    rd(cmp_a(0), d); chk(tag, "cmp0", d, 32'(m_cmp_act[0]));
    rd(cmp_a(1), d); chk(tag, "cmp1", d, 32'(m_cmp_act[1]));
    rd(ctl_a(0), d); chk(tag, "ctl0", d, exp_ctl(0));
  endtask

  task automatic run_check(input string tag, input int n);
    repeat (n) begin
      idle(1);
      check_state(tag);
    end
  endtask

  task automatic stop_clear();
    wr(A_SC, 32'h0);
    wr(A_CNT, 32'h0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] d;
    rd(A_INFO, d); chk("R1", "info", d, 32'(NCH));
    rd(A_GLB, d);  chk("R1", "global", d, 32'h0);
    rd(A_SC, d);   chk("R2", "ctrl reset", d, 32'h0);
    rd(A_CNT, d);  chk("R3", "count reset", d, 32'h0);
    rd(A_PER, d);  chk("R4", "period reset", d, 32'hFFFF);
    for (int i = 0; i < NCH; i++) begin
      rd(cmp_a(i), d); chk("R4", "cmp reset", d, 32'h0);
      rd(ctl_a(i), d); chk("R6", "ctl reset", d, 32'h0);
    end
    chk("R6", "outputs reset", 32'(pwm_out), 32'h0);
  endtask

  task automatic t_info_ro();
    logic [31:0] d;
    wr(A_INFO, 32'h55);
    rd(A_INFO, d); chk("R1", "info after write", d, 32'(NCH));
    wr(A_GLB, 32'hFFFF_FFFF);
    rd(A_GLB, d);  chk("R1", "global after write", d, 32'h0);
  endtask

  task automatic t_center_bit();
    logic [31:0] d;
    wr(A_SC, 32'h20);
    rd(A_SC, d); chk("R2", "centre bit ignored", d, 32'h00);
    wr(A_SC, 32'h3F);
    rd(A_SC, d); chk("R2", "fields kept, bit5 zero", d, 32'h1F);
    stop_clear();
  endtask

  task automatic t_stopped_writes();
    logic [31:0] d;
    stop_clear();
    wr(A_PER, 32'h9);
    rd(A_PER, d); chk("R4", "period immediate", d, 32'h9);
    wr(cmp_a(0), 32'h4);
    rd(cmp_a(0), d); chk("R4", "cmp immediate", d, 32'h4);
    idle(3);
    check_state("R3");   // stopped counter holds
  endtask

  task automatic t_run_basic();
    stop_clear();
    wr(A_PER, 32'd9);
    wr(cmp_a(0), 32'd4);
    wr(ctl_a(0), 32'h28);
    wr(A_SC, 32'h08);
    check_state("R3");
    run_check("R7", 24);
  endtask

  task automatic t_prescale();
    stop_clear();
    wr(A_PER, 32'd5);
    wr(A_SC, 32'h0A);           // divide by 4
    run_check("R3", 30);
    stop_clear();
    wr(A_SC, 32'h0B);           // divide by 8
    run_check("R3", 20);
  endtask

  task automatic t_counter_clear();
    logic [31:0] d;
    stop_clear();
    wr(A_PER, 32'd9);
    wr(A_SC, 32'h08);
    idle(5);
    wr(A_CNT, 32'h1234);
    rd(A_CNT, d); chk("R3", "count cleared", d, 32'h0);
    run_check("R3", 4);
  endtask

  task automatic t_buffered();
    logic [31:0] d;
    stop_clear();
    wr(A_PER, 32'd9);
    wr(cmp_a(0), 32'd4);
    wr(ctl_a(0), 32'h28);
    wr(A_SC, 32'h08);
    idle(3);
    wr(cmp_a(0), 32'd7);
    rd(cmp_a(0), d); chk("R5", "cmp held while running", d, 32'd4);
    wr(A_PER, 32'd5);
    rd(A_PER, d); chk("R5", "period held while running", d, 32'd9);
    run_check("R5", 24);
    rd(A_PER, d); chk("R5", "period loaded at wrap", d, 32'd5);
    rd(cmp_a(0), d); chk("R5", "cmp loaded at wrap", d, 32'd7);
  endtask

  task automatic t_polarity_now();
    stop_clear();
    wr(A_PER, 32'd9);
    wr(cmp_a(0), 32'd5);
    wr(ctl_a(0), 32'h28);
    wr(A_SC, 32'h08);
    idle(2);
    wr(ctl_a(0), 32'h24);       // inverted, mid-period
    chk("R8", "inverted at once", 32'(pwm_out[0]), 32'(exp_out() & 4'b0001));
    check_state("R8");
    idle(1);
    wr(ctl_a(0), 32'h20);       // off, mid-period
    chk("R8", "off at once", 32'(pwm_out[0]), 32'h0);
    run_check("R8", 6);
  endtask

  task automatic t_disabled();
    stop_clear();
    wr(A_PER, 32'd7);
    for (int i = 1; i < NCH; i++) wr(cmp_a(i), 32'd20);
    wr(ctl_a(1), 32'h2C);       // select 11
    wr(ctl_a(2), 32'h20);       // select 00
    wr(ctl_a(3), 32'h08);       // normal select, edge enable clear
    wr(A_SC, 32'h08);
    repeat (10) begin
      idle(1);
      chk("R6", "disabled outputs low", 32'(pwm_out[3:1]), 32'h0);
    end
    run_check("R6", 4);
  endtask

  task automatic t_bounds();
    stop_clear();
    wr(A_PER, 32'd9);
    wr(cmp_a(0), 32'd0);
    wr(cmp_a(1), 32'd20);
    wr(ctl_a(0), 32'h28);
    wr(ctl_a(1), 32'h28);
    wr(A_SC, 32'h08);
    repeat (22) begin
      idle(1);
      chk("R7", "cmp 0 low", 32'(pwm_out[0]), 32'h0);
      chk("R7", "cmp above period high", 32'(pwm_out[1]), 32'h1);
    end
    wr(ctl_a(1), 32'h24);
    chk("R7", "inverted cmp above period low", 32'(pwm_out[1]), 32'h0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    stop_clear();
    wr(ctl_a(0), 32'hA8);       // enable, clear flag
    wr(ctl_a(1), 32'h80);       // disabled, clear flag
    wr(A_PER, 32'd3);
    wr(A_SC, 32'h08);
    idle(6);
    wr(A_SC, 32'h0);
    rd(ctl_a(0), d); chk("R9", "flag set on wrap", d, 32'hA8);
    rd(ctl_a(1), d); chk("R9", "disabled flag untouched", d, 32'h00);
    wr(ctl_a(0), 32'h28);
    rd(ctl_a(0), d); chk("R9", "write 0 keeps flag", d, 32'hA8);
    wr(ctl_a(0), 32'hA8);
    rd(ctl_a(0), d); chk("R9", "write 1 clears flag", d, 32'h28);
    check_state("R9");
  endtask

  task automatic t_indep();
    stop_clear();
    wr(A_PER, 32'd11);
    wr(cmp_a(0), 32'd3);  wr(ctl_a(0), 32'h28);
    wr(cmp_a(1), 32'd8);  wr(ctl_a(1), 32'h24);
    wr(cmp_a(2), 32'd11); wr(ctl_a(2), 32'h38);
    wr(cmp_a(3), 32'd0);  wr(ctl_a(3), 32'h24);
    wr(A_SC, 32'h08);
    run_check("R10", 30);
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_info_ro();
    t_center_bit();
    t_stopped_writes();
    t_run_basic();
    t_prescale();
    t_counter_clear();
    t_buffered();
    t_polarity_now();
    t_disabled();
    t_bounds();
    t_flags();
    t_indep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule